// File: doc/BRIEF.md
# PWM Generator Status and Trigger Register

This block is the status/control word of one PWM generator. It keeps sticky event flags for five protection and control inputs: sync, fault 2, fault 1, current limit and feed-forward. It also shows the live level of each of those inputs. Write-one strobes start or stop a PWM cycle and request a transfer of user data into the active registers. Live status from the generator core is shown in the same word: trigger, update pending, capture, push-pull phase and center-aligned half. The waveform itself is generated elsewhere.

Software reaches the word over a minimal register bus with an address, a write enable, write data and combinational read data. An event flag is raised on a rising edge of its input while the module is enabled. It is also raised when the input is already high at the moment the module becomes enabled. Software clears a flag by writing 0 to its bit. The core sees the trigger state and the update-pending state, a data-write permit for the user data registers, and a one-cycle transfer pulse.

Top module: `pwm_stat_reg`

## Requirements
- R1: After reset the flags at bits 20:16, the capture flag (bit 5), trigger (bit 0) and update-pending (bit 4) are all 0, and `data_wr_ok` is 1.
- R2: While `enable` is 1, a 0-to-1 change of `evt_in[i]` sets flag bit 16+i (event order from `evt_in[4]` to `evt_in[0]`: sync, fault 2, fault 1, current limit, feed-forward) on the next clock edge.
- R3: When `enable` goes from 0 to 1 while `evt_in[i]` is already 1, flag bit 16+i is set on that edge.
- R4: A flag stays set after its input falls, and no flag is set while `enable` is 0.
- R5: A write to the register clears every flag (bits 20:16 and bit 5) whose write-data bit is 0 and keeps those written 1; a hardware set in the same cycle wins over the clear.
- R6: Read bits 12:8 equal `evt_in[4:0]` live, bit 13 equals `cap_live`, bit 2 equals `pp_phase` and bit 1 equals `ca_half`.
- R7: Writing 1 to bit 7 sets the trigger (bit 0 and `trig`) on the next edge; bits 7, 6 and 3 always read 0.
- R8: Writing 1 to bit 6 clears the trigger; when bits 7 and 6 are written 1 together, the trigger ends up 0.
- R9: A `cycle_end` pulse clears the trigger only when `single_shot` is 1; a start strobe in the same cycle keeps it set.
- R10: Writing 1 to bit 3 sets update-pending (bit 4 and `upd_pending`) on the next edge, and `data_wr_ok` is 0 while it is set.
- R11: `upd_xfer` is 1 exactly in cycles where `upd_strobe` is 1 and an update is pending; the pending flag then clears, unless a new request is written in that cycle.
- R12: A `cap_evt` pulse sets bit 5, which stays set until cleared by the write rule of R5.
- R13: When `addr` differs from `REG_ADDR`, `rd_data` is 0 and writes change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Module enable |
| addr | input | ADDR_W | Register address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data (combinational) |
| evt_in | input | 5 | Event inputs: [4] sync, [3] fault 2, [2] fault 1, [1] current limit, [0] feed-forward |
| cap_evt | input | 1 | Time-base capture pulse |
| cap_live | input | 1 | Live capture status |
| pp_phase | input | 1 | Push-pull phase from core |
| ca_half | input | 1 | Center-aligned half from core |
| single_shot | input | 1 | Core runs single-shot cycles |
| cycle_end | input | 1 | End-of-cycle pulse from core |
| upd_strobe | input | 1 | End-of-cycle update point from core |
| trig | output | 1 | PWM cycle in progress |
| upd_pending | output | 1 | Data update pending |
| data_wr_ok | output | 1 | User data registers may be written |
| upd_xfer | output | 1 | Transfer user data to active registers |

## Verification
The enable-edge rule is swept over all 32 input patterns with the inputs held high before enable rises. This separates the enable-time set from the edge set. The rising-edge rule gets a second sweep of all 32 patterns, each followed by a partial clear with a rotated keep mask. That shows that write-0-clears works per bit and that flags survive inputs falling. All eight combinations of start, stop and prior trigger state are applied, and the end-of-cycle pulse is applied in both run modes. These pin down the priority order. Update strobes are given with and without a pending request, and together with a new request, to tell the transfer pulse apart from the clearing of the pending flag.

// File: rtl/pwm_stat_pkg.sv
package pwm_stat_pkg;
  localparam int N_EVT        = 5;
  localparam int FLAG_LSB     = 16;
  localparam int LIVE_LSB     = 8;
  localparam int CAP_LIVE_BIT = 13;
  localparam int START_BIT    = 7;
  localparam int STOP_BIT     = 6;
  localparam int CAP_BIT      = 5;
  localparam int PEND_BIT     = 4;
  localparam int REQ_BIT      = 3;
  localparam int PHASE_BIT    = 2;
  localparam int HALF_BIT     = 1;
  localparam int TRIG_BIT     = 0;

  typedef struct packed {
    logic             hit;
    logic             start;
    logic             stop;
    logic             upd_req;
    logic [N_EVT-1:0] flag_keep;
    logic             cap_keep;
  } wr_cmd_t;
endpackage

// File: rtl/pwm_bus_decode.sv
module pwm_bus_decode
  import pwm_stat_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] REG_ADDR = '0,
  parameter int DATA_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output wr_cmd_t           cmd
);
  logic sel;

  always_comb begin
    sel           = (addr == REG_ADDR);
    cmd.hit       = sel && wr_en;
    cmd.start     = cmd.hit && wr_data[START_BIT];
    cmd.stop      = cmd.hit && wr_data[STOP_BIT];
    cmd.upd_req   = cmd.hit && wr_data[REQ_BIT];
    cmd.flag_keep = wr_data[FLAG_LSB +: N_EVT];
    cmd.cap_keep  = wr_data[CAP_BIT];
  end
endmodule

// File: rtl/pwm_evt_flags.sv
module pwm_evt_flags #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enable,
  input  logic [N-1:0] evt_in,
  input  logic         wr_hit,
  input  logic [N-1:0] keep,
  output logic [N-1:0] flags,
  output logic [N-1:0] evt_q
);
  logic         en_q;
  logic [N-1:0] flags_nxt;
  logic [N-1:0] hw_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      evt_q <= '0;
    end else begin
      en_q  <= enable;
      evt_q <= evt_in;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_comb begin
      hw_set[i] = enable && evt_in[i] && (!evt_q[i] || !en_q);
      if (hw_set[i])
        flags_nxt[i] = 1'b1;
      else if (wr_hit && !keep[i])
        flags_nxt[i] = 1'b0;
      else
        flags_nxt[i] = flags[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        flags[i] <= 1'b0;
      else
        flags[i] <= flags_nxt[i];
    end
  end
endmodule

// File: rtl/pwm_trig_ctl.sv
module pwm_trig_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic stop,
  input  logic single_shot,
  input  logic cycle_end,
  output logic trig
);
  logic trig_nxt;

  always_comb begin
    if (stop)
      trig_nxt = 1'b0;
    else if (start)
      trig_nxt = 1'b1;
    else if (single_shot && cycle_end)
      trig_nxt = 1'b0;
    else
      trig_nxt = trig;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      trig <= 1'b0;
    else
      trig <= trig_nxt;
  end
endmodule

// File: rtl/pwm_upd_ctl.sv
module pwm_upd_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic strobe,
  output logic pending,
  output logic xfer
);
  logic pend_nxt;

  always_comb begin
    xfer = pending && strobe;
    if (req)
      pend_nxt = 1'b1;
    else if (strobe)
      pend_nxt = 1'b0;
    else
      pend_nxt = pending;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pending <= 1'b0;
    else
      pending <= pend_nxt;
  end
endmodule

// File: rtl/pwm_stat_reg.sv
module pwm_stat_reg
  import pwm_stat_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] REG_ADDR = '0,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic [4:0]        evt_in,
  input  logic              cap_evt,
  input  logic              cap_live,
  input  logic              pp_phase,
  input  logic              ca_half,
  input  logic              single_shot,
  input  logic              cycle_end,
  input  logic              upd_strobe,
  output logic              trig,
  output logic              upd_pending,
  output logic              data_wr_ok,
  output logic              upd_xfer
);
  logic             rst_meta;
  logic             rst_n_s;
  wr_cmd_t          cmd;
  logic [N_EVT-1:0] evt_flag;
  logic [N_EVT-1:0] evt_q;
  logic             cap_flag;
  logic             cap_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_n_s  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_n_s  <= rst_meta;
    end
  end

  pwm_bus_decode #(
    .ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR), .DATA_W(DATA_W)
  ) i_dec (
    .addr(addr), .wr_en(wr_en), .wr_data(wr_data), .cmd(cmd)
  );

  pwm_evt_flags #(.N(N_EVT)) i_flags (
    .clk(clk), .rst_n(rst_n_s), .enable(enable), .evt_in(evt_in),
    .wr_hit(cmd.hit), .keep(cmd.flag_keep), .flags(evt_flag), .evt_q(evt_q)
  );

  pwm_trig_ctl i_trig (
    .clk(clk), .rst_n(rst_n_s), .start(cmd.start), .stop(cmd.stop),
    .single_shot(single_shot), .cycle_end(cycle_end), .trig(trig)
  );

  pwm_upd_ctl i_upd (
    .clk(clk), .rst_n(rst_n_s), .req(cmd.upd_req), .strobe(upd_strobe),
    .pending(upd_pending), .xfer(upd_xfer)
  );

  always_comb begin
    if (cap_evt)
      cap_nxt = 1'b1;
    else if (cmd.hit && !cmd.cap_keep)
      cap_nxt = 1'b0;
    else
      cap_nxt = cap_flag;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)
      cap_flag <= 1'b0;
    else
      cap_flag <= cap_nxt;
  end

  assign data_wr_ok = !upd_pending;

  always_comb begin
    rd_data = '0;
    if (addr == REG_ADDR) begin
      rd_data[FLAG_LSB +: N_EVT] = evt_flag;
      rd_data[LIVE_LSB +: N_EVT] = evt_in;
      rd_data[CAP_LIVE_BIT]      = cap_live;
      rd_data[CAP_BIT]           = cap_flag;
      rd_data[PEND_BIT]          = upd_pending;
      rd_data[PHASE_BIT]         = pp_phase;
      rd_data[HALF_BIT]          = ca_half;
      rd_data[TRIG_BIT]          = trig;
    end
  end
endmodule

// File: rtl/pwm_stat_chk.sv
module pwm_stat_chk #(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] REG_ADDR = '0,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n_s,
  input logic              enable,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] rd_data,
  input logic [4:0]        evt_in,
  input logic [4:0]        evt_q,
  input logic [4:0]        evt_flag,
  input logic              upd_strobe,
  input logic              trig,
  input logic              upd_pending,
  input logic              upd_xfer
);
  logic hit;
  assign hit = wr_en && (addr == REG_ADDR);

  for (genvar i = 0; i < 5; i++) begin : g_evt
    // R2
    edge_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
      (enable && evt_in[i] && !evt_q[i]) |=> evt_flag[i]);
    // R5
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
      (evt_flag[i] && !(hit && !wr_data[16+i])) |=> evt_flag[i]);
  end

  // R7
  start_sets_trig_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (hit && wr_data[7] && !wr_data[6]) |=> trig);
  // R7
  strobe_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rd_data[7] == 1'b0) && (rd_data[6] == 1'b0) && (rd_data[3] == 1'b0));
  // R8
  stop_clears_trig_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (hit && wr_data[6]) |=> !trig);
  // R10
  req_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (hit && wr_data[3]) |=> upd_pending);
  // R11
  xfer_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    upd_xfer |-> (upd_pending && upd_strobe));
  // R11
  strobe_clears_pend_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (upd_strobe && !(hit && wr_data[3])) |=> !upd_pending);
  // R13
  other_addr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (addr != REG_ADDR) |-> (rd_data == '0));
endmodule

bind pwm_stat_reg pwm_stat_chk #(
  .ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR), .DATA_W(DATA_W)
) i_chk (
  .clk(clk), .rst_n_s(rst_n_s), .enable(enable), .addr(addr), .wr_en(wr_en),
  .wr_data(wr_data), .rd_data(rd_data), .evt_in(evt_in), .evt_q(evt_q),
  .evt_flag(evt_flag), .upd_strobe(upd_strobe), .trig(trig),
  .upd_pending(upd_pending), .upd_xfer(upd_xfer)
);

// File: tb/test_pwm_stat_reg.sv
module test_pwm_stat_reg;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        enable;
  logic [3:0]  addr;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic [4:0]  evt_in;
  logic        cap_evt, cap_live, pp_phase, ca_half;
  logic        single_shot, cycle_end, upd_strobe;
  logic        trig, upd_pending, data_wr_ok, upd_xfer;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  pwm_stat_reg i_pwm_stat_reg (
    .clk(clk), .rst_n(rst_n), .enable(enable), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .evt_in(evt_in), .cap_evt(cap_evt),
    .cap_live(cap_live), .pp_phase(pp_phase), .ca_half(ca_half),
    .single_shot(single_shot), .cycle_end(cycle_end), .upd_strobe(upd_strobe),
    .trig(trig), .upd_pending(upd_pending), .data_wr_ok(data_wr_ok),
    .upd_xfer(upd_xfer)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one cycle with a write presented, inputs change at negedge
  task automatic wr(input logic [31:0] d);
    addr = 4'h0; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  function automatic logic [4:0] flags_of(input logic [31:0] r);
    return r[20:16];
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; enable = 0; addr = 0; wr_en = 0; wr_data = 0; evt_in = 0;
    cap_evt = 0; cap_live = 0; pp_phase = 0; ca_half = 0;
    single_shot = 0; cycle_end = 0; upd_strobe = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check("R1 rd", rd_data, 32'h0);
    check("R1 trig", {31'b0, trig}, 32'h0);
    check("R1 pend", {31'b0, upd_pending}, 32'h0);
    check("R1 wr_ok", {31'b0, data_wr_ok}, 32'h1);

    // R3 enable-edge sweep over all patterns
    for (int p = 0; p < 32; p++) begin
      enable = 0; evt_in = p[4:0];
      idle();
      wr(32'h0);
      check("R4 no set while disabled", {27'b0, flags_of(rd_data)}, 32'h0);
      enable = 1;
      idle();
      check("R3 enable edge", {27'b0, flags_of(rd_data)}, {27'b0, p[4:0]});
      wr(32'h0);
      check("R5 clear all", {27'b0, flags_of(rd_data)}, 32'h0);
      enable = 0; evt_in = 0;
      idle();
    end

    // R2 rising-edge sweep, R4 sticky, R5 partial clear, R6 live mirror
    enable = 1;
    idle();
    for (int p = 0; p < 32; p++) begin
      logic [4:0] keep;
      keep = {p[0], p[4:1]} ^ 5'b10101;
      evt_in = p[4:0];
      #1;
      check("R6 live mirror", {27'b0, rd_data[12:8]}, {27'b0, p[4:0]});
      idle();
      check("R2 edge set", {27'b0, flags_of(rd_data)}, {27'b0, p[4:0]});
      evt_in = 0;
      idle();
      check("R4 sticky", {27'b0, flags_of(rd_data)}, {27'b0, p[4:0]});
      wr({11'b0, keep, 16'b0});
      check("R5 keep mask", {27'b0, flags_of(rd_data)}, {27'b0, p[4:0] & keep});
      wr(32'h0);
    end

    // R5 set wins over clear in same cycle
    evt_in = 5'b00100; addr = 0; wr_data = 32'h0; wr_en = 1;
    @(negedge clk); wr_en = 0;
    check("R5 set wins", {27'b0, flags_of(rd_data)}, 32'h4);
    evt_in = 0; wr(32'h0);

    // R6 core status mirrors
    for (int p = 0; p < 8; p++) begin
      cap_live = p[2]; pp_phase = p[1]; ca_half = p[0];
      #1;
      check("R6 status mirror", {29'b0, rd_data[13], rd_data[2], rd_data[1]}, {29'b0, p[2:0]});
    end
    cap_live = 0; pp_phase = 0; ca_half = 0;

    // R7 R8 trigger priority sweep
    for (int p = 0; p < 8; p++) begin
      logic exp_t;
      if (p[2]) wr(32'h80); else wr(32'h40);
      wr({24'b0, p[0], p[1], 6'b0});
      exp_t = p[1] ? 1'b0 : (p[0] ? 1'b1 : p[2]);
      check("R8 trig priority", {31'b0, rd_data[0]}, {31'b0, exp_t});
      check("R7 strobe bits read 0", {29'b0, rd_data[7], rd_data[6], rd_data[3]}, 32'h0);
    end

    // R9 single-shot end
    for (int p = 0; p < 4; p++) begin
      wr(32'h80);
      single_shot = p[0]; cycle_end = 1;
      if (p[1]) wr(32'h80); else idle();
      cycle_end = 0; single_shot = 0;
      check("R9 cycle end", {31'b0, trig}, {31'b0, (p[0] && !p[1]) ? 1'b0 : 1'b1});
    end
    wr(32'h40);

    // R10 R11 update handshake
    upd_strobe = 1; #1;
    check("R11 no xfer idle", {31'b0, upd_xfer}, 32'h0);
    idle(); upd_strobe = 0;
    wr(32'h8);
    check("R10 pending", {31'b0, rd_data[4]}, 32'h1);
    check("R10 wr blocked", {31'b0, data_wr_ok}, 32'h0);
    upd_strobe = 1; #1;
    check("R11 xfer", {31'b0, upd_xfer}, 32'h1);
    wr(32'h8);
    upd_strobe = 0;
    check("R11 req with strobe", {31'b0, upd_pending}, 32'h1);
    upd_strobe = 1; idle(); upd_strobe = 0;
    check("R11 cleared", {31'b0, upd_pending}, 32'h0);
    check("R10 wr allowed", {31'b0, data_wr_ok}, 32'h1);

    // R12 capture flag
    cap_evt = 1; idle(); cap_evt = 0; idle();
    check("R12 cap set", {31'b0, rd_data[5]}, 32'h1);
    wr(32'h20);
    check("R12 cap kept", {31'b0, rd_data[5]}, 32'h1);
    wr(32'h0);
    check("R12 cap cleared", {31'b0, rd_data[5]}, 32'h0);

    // R13 other address
    addr = 4'h1; wr_data = 32'h0000_0088; wr_en = 1;
    @(negedge clk); wr_en = 0;
    check("R13 read other", rd_data, 32'h0);
    addr = 4'h0; #1;
    check("R13 write ignored", {30'b0, trig, upd_pending}, 32'h0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule